// File: doc/BRIEF.md
# Dual-Clock Reconfigurable Line-Delay Buffer

This block is a line buffer built on a dual-port memory. A write port and a read port run on separate clocks. Each port steps its own address counter through the array. A word stored on the write side comes back out on the read side once the read counter reaches that address. Starting the read side a chosen number of cycles after the write side therefore delays a scan line by that many words. Running the two clocks at different rates converts the data rate between two units. There are no full or empty flags: each counter wraps silently at the end of the array.

The word organization is taken from a mode pin whenever a side is held in its synchronous reset. Low selects `DEPTH` words of 16 bits and high selects `2*DEPTH` words of 8 bits. Each side keeps its own copy of the choice, so one side can be set up as bytes and the other as words. In byte organization, byte addresses select the low or high lane of a 16-bit storage word. The read data is registered. A registered drive-enable stands in for a tri-state output, so the block can sit inside a larger design. `DEPTH` must be a power of two.

Top module: `line_delay_buf`

## Requirements
- R1: While a side's reset is low, that side latches `mode_narrow` and keeps it until its next reset. 0 selects `DEPTH` words of 16 bits and 1 selects `2*DEPTH` words of 8 bits. The two sides latch independently.
- R2: `wr_rst_n` and `rd_rst_n` are active-low reset strobes, sampled on their own clock. Each returns only its own side's address to 0. No word is stored during a write reset cycle, and no read happens during a read reset cycle.
- R3: `wr_en_n` is active low. On a write clock edge with it high, nothing is stored and the write address holds.
- R4: `rd_en_n` is active low. On a read clock edge with it high, the read address and the registered read word both hold.
- R5: On a read clock edge with `rd_en_n` low, the word at the read address is registered and appears on `rd_data` after that edge. A word written earlier is returned unchanged, so a read stream started D cycles after the write stream returns it delayed by D cycles.
- R6: `out_en_n` is sampled on every read clock edge. After an edge with it low, `rd_drive` is 1 and `rd_data` carries the read word. After an edge with it high, `rd_drive` is 0 and `rd_data` is 0. It has no effect on read addressing.
- R7: In byte organization only `wr_data[7:0]` is stored and `wr_data[15:8]` is ignored. An even byte address uses the low lane (bits 7:0) of storage word address/2, and an odd one uses its high lane (bits 15:8). Reads return the byte in bits 7:0 with bits 15:8 zero.
- R8: Each address counter wraps to 0 after the last address of its side's organization: `DEPTH-1` for words, `2*DEPTH-1` for bytes. No flag is raised.
- R9: Write and read run on unrelated clocks, and the two streams may proceed at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write address reset strobe, active low |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | 16 | Write data |
| mode_narrow | input | 1 | Organization select sampled during either reset (1 = bytes) |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read address reset strobe, active low |
| rd_en_n | input | 1 | Read enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| rd_data | output | 16 | Read data (0 while not driven) |
| rd_drive | output | 1 | Output drive enable, stands in for the tri-state control |

## Verification
The hardest case to reach is a mixed organization: bytes written on one side and read back as words on the other. It needs the two resets applied at different times with different mode levels. The bench writes a full byte-organized line, then resets only the read side with the mode pin low. It then checks that each word joins its odd byte above its even byte. Rewinding one side while the other keeps its position is reached in the same way. The bench interleaves single-side resets with reads that expect the untouched side's old address to continue.

// File: rtl/line_delay_buf.sv
module line_delay_buf #(
  parameter int DEPTH = 64
) (
  input  logic        wr_clk,
  input  logic        wr_rst_n,
  input  logic        wr_en_n,
  input  logic [15:0] wr_data,
  input  logic        mode_narrow,
  input  logic        rd_clk,
  input  logic        rd_rst_n,
  input  logic        rd_en_n,
  input  logic        out_en_n,
  output logic [15:0] rd_data,
  output logic        rd_drive
);
  localparam int AW = $clog2(2 * DEPTH);
  localparam int WW = AW - 1;
  localparam logic [AW-1:0] LAST_W = AW'(DEPTH - 1);
  localparam logic [AW-1:0] LAST_N = AW'(2 * DEPTH - 1);

  logic [7:0] mem_lo [DEPTH];
  logic [7:0] mem_hi [DEPTH];

  // write side
  logic          wr_narrow;
  logic [AW-1:0] wr_ptr;
  wire  [AW-1:0] wr_last = wr_narrow ? LAST_N : LAST_W;
  wire  [WW-1:0] wr_idx  = wr_narrow ? wr_ptr[AW-1:1] : wr_ptr[WW-1:0];
  wire           wr_go   = wr_rst_n && !wr_en_n;

  always_ff @(posedge wr_clk) begin
    if (!wr_rst_n) begin
      wr_ptr    <= '0;
      wr_narrow <= mode_narrow;
    end else if (!wr_en_n) begin
      wr_ptr <= (wr_ptr == wr_last) ? '0 : wr_ptr + 1'b1;
    end
  end

  always_ff @(posedge wr_clk) begin
    if (wr_go) begin
      if (!wr_narrow) begin
        mem_lo[wr_idx] <= wr_data[7:0];
        mem_hi[wr_idx] <= wr_data[15:8];
      end else if (wr_ptr[0]) begin
        mem_hi[wr_idx] <= wr_data[7:0];
      end else begin
        mem_lo[wr_idx] <= wr_data[7:0];
      end
    end
  end

  // read side
  logic          rd_narrow;
  logic [AW-1:0] rd_ptr;
  logic [15:0]   rd_q;
  wire  [AW-1:0] rd_last = rd_narrow ? LAST_N : LAST_W;
  wire  [WW-1:0] rd_idx  = rd_narrow ? rd_ptr[AW-1:1] : rd_ptr[WW-1:0];
  wire  [7:0]    rd_byte = rd_ptr[0] ? mem_hi[rd_idx] : mem_lo[rd_idx];
  wire  [15:0]   rd_next = rd_narrow ? {8'h00, rd_byte} : {mem_hi[rd_idx], mem_lo[rd_idx]};

  always_ff @(posedge rd_clk) begin
    if (!rd_rst_n) begin
      rd_ptr    <= '0;
      rd_narrow <= mode_narrow;
    end else if (!rd_en_n) begin
      rd_ptr <= (rd_ptr == rd_last) ? '0 : rd_ptr + 1'b1;
      rd_q   <= rd_next;
    end
  end

  always_ff @(posedge rd_clk) rd_drive <= !out_en_n;

  assign rd_data = rd_drive ? rd_q : '0;

  // R3
  wr_hold_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_en_n |=> $stable(wr_ptr));
  // R4
  rd_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_en_n |=> $stable(rd_ptr) && $stable(rd_q));
  // R8
  wr_wrap_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (!wr_en_n && wr_ptr == wr_last) |=> wr_ptr == '0);
  // R8
  rd_wrap_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (!rd_en_n && rd_ptr == rd_last) |=> rd_ptr == '0);
  // R8
  wr_range_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    wr_ptr <= wr_last);
  // R8
  rd_range_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    rd_ptr <= rd_last);
  // R1
  wr_mode_hold_chk: assert property (@(posedge wr_clk)
    (wr_rst_n && $past(wr_rst_n)) |-> $stable(wr_narrow));
  // R1
  rd_mode_hold_chk: assert property (@(posedge rd_clk)
    (rd_rst_n && $past(rd_rst_n)) |-> $stable(rd_narrow));
  // R2
  rd_reset_chk: assert property (@(posedge rd_clk)
    !rd_rst_n |=> rd_ptr == '0);
endmodule

// File: tb/test_line_delay_buf.sv
module test_line_delay_buf;
  localparam int DEPTH = 16;

  logic wclk = 0, rclk = 0;
  logic wrst_n = 1, rrst_n = 1, mode = 0;
  logic wen_n = 1, ren_n = 1, oen_n = 1;
  logic [15:0] wdat = '0;
  logic [15:0] rdat;
  logic rdrv;
  int nchk = 0, nbad = 0;

  always #5 wclk = ~wclk;
  initial begin
    #3;
    forever #5 rclk = ~rclk;
  end

  line_delay_buf #(.DEPTH(DEPTH)) i_line_delay_buf (
    .wr_clk(wclk), .wr_rst_n(wrst_n), .wr_en_n(wen_n), .wr_data(wdat),
    .mode_narrow(mode), .rd_clk(rclk), .rd_rst_n(rrst_n), .rd_en_n(ren_n),
    .out_en_n(oen_n), .rd_data(rdat), .rd_drive(rdrv));

  function automatic logic [15:0] pa(input int i); return 16'(16'h1357 * (i + 1)); endfunction
  function automatic logic [15:0] qa(input int i); return 16'(16'h7A31 + 16'h0202 * i); endfunction
  function automatic logic [15:0] lb(input int i); return 16'(16'h0F0F * i) ^ 16'h5A5A; endfunction
  function automatic logic [7:0]  nb(input int i); return 8'(8'h3B * (i + 1)); endfunction

  task automatic ck(input string tag, input logic [16:0] act, input logic [16:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic en, input logic [15:0] d);
    @(negedge wclk);
    wen_n = !en; wdat = d;
    @(posedge wclk); #1;
    wen_n = 1;
  endtask

  task automatic rop(input logic en, input logic oe, input logic [15:0] ed,
                     input logic edrv, input string tag);
    @(negedge rclk);
    ren_n = !en; oen_n = !oe;
    @(posedge rclk); #1;
    ren_n = 1;
    ck(tag, {edrv, rdat}, {edrv, edrv ? ed : 16'h0});
    if (rdrv !== edrv) ck({tag, " drive"}, {16'h0, rdrv}, {16'h0, edrv});
  endtask

  task automatic wreset(input logic m);
    @(negedge wclk); wrst_n = 0; mode = m;
    @(posedge wclk); #1; wrst_n = 1;
  endtask

  task automatic rreset(input logic m);
    @(negedge rclk); rrst_n = 0; mode = m;
    @(posedge rclk); #1; rrst_n = 1;
  endtask

  initial begin
    #3_000_000;
    nchk++; nbad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    wreset(0); rreset(0);
    // R6 reset state: not driven, bus zero
    rop(0, 0, 16'h0, 0, "R6 idle after reset");

    // R1 word organization, R3 disable cycle, R5 registered read
    for (int i = 0; i < DEPTH; i++) begin
      wr(1, pa(i));
      if (i == 7) wr(0, 16'hDEAD);
    end
    for (int i = 0; i < DEPTH; i++) rop(1, 1, pa(i), 1, "R5 R1 R3 word read");
    rop(0, 1, pa(DEPTH - 1), 1, "R4 read disable holds");
    rop(1, 1, pa(0), 1, "R8 read wraps at DEPTH-1");
    rop(1, 0, 16'h0, 0, "R6 output off");
    rop(1, 1, pa(2), 1, "R6 addressing continues while off");

    // R8 write wrap, R2 single-side rewinds
    for (int i = 0; i < 3; i++) wr(1, qa(i));
    rop(1, 1, pa(3), 1, "R2 read pointer untouched by writes");
    rreset(0);
    rop(1, 1, qa(0), 1, "R2 R8 read reset, write wrapped");
    rop(1, 1, qa(1), 1, "R2 after read reset");
    wreset(0);
    wr(1, 16'hC0DE);
    rop(1, 1, qa(2), 1, "R2 read side unaffected by write reset");
    rreset(0);
    rop(1, 1, 16'hC0DE, 1, "R2 write reset rewound write pointer");

    // R9 concurrent line delay
    wreset(0); rreset(0);
    fork
      begin
        for (int i = 0; i < 40; i++) wr(1, lb(i));
      end
      begin
        for (int k = 0; k < 4; k++) rop(0, 1, 16'hC0DE, 1, "R4 idle before delayed stream");
        for (int i = 0; i < 40; i++) rop(1, 1, lb(i), 1, "R9 R5 delayed line");
      end
    join

    // R7 byte organization
    wreset(1); rreset(1);
    for (int i = 0; i < 2 * DEPTH; i++) wr(1, {~nb(i), nb(i)});
    for (int i = 0; i < 2 * DEPTH; i++) rop(1, 1, {8'h00, nb(i)}, 1, "R7 R1 byte read");
    rop(1, 1, {8'h00, nb(0)}, 1, "R8 byte wrap at 2*DEPTH-1");
    rreset(0);
    for (int k = 0; k < DEPTH; k++)
      rop(1, 1, {nb(2 * k + 1), nb(2 * k)}, 1, "R7 R1 lanes read as words");

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule